// File: doc/BRIEF.md
# Multiplexed DRAM-to-SRAM Adapter

This block lets a video controller that expects a pair of 64K-word multiplexed DRAM banks run on one flat 128K-word static RAM. The controller puts the low half of the address on an 8-bit bus and pulls its row strobe low. It then puts the high half on the same bus and pulls one of its two bank column strobes low. The adapter stores the row half in a register on the row strobe's falling edge. It then presents a flat 17-bit address to the memory, with the active bank column strobe as the top bit.

Either bank column strobe low selects the memory. An active expansion column strobe vetoes the select. The memory's output enable stays active, and the controller's write enable alone sets the direction. A refresh cycle, with the row strobe and no column strobe, only reloads the row register. An access runs on past the rise of the row strobe for as long as a column strobe stays low.

The strobes are sampled by the chip clock `clk_i`, which must be fast enough to see each strobe phase for at least one cycle.

Top module: `dram_sram_bridge`

## Requirements
- R1: While the memory is selected, `mem_addr_o` = {bank, `vaddr_i` (column half), stored row}. The stored row goes to bits [7:0], the column to bits [15:8] and the bank to bit 16.
- R2: The row register loads `vaddr_i` at the first clock that samples `ras_ni` low after it was sampled high. Changes to `vaddr_i` while `ras_ni` stays low do not alter it.
- R3: `mem_cs_no` is low exactly when (`cas0_ni` low or `cas1_ni` low) and `casx_ni` is high.
- R4: Bit 16 of `mem_addr_o` is 1 when only `cas1_ni` is low and 0 when `cas0_ni` is low.
- R5: With `casx_ni` low, `mem_cs_no` and `mem_we_no` are high and `vdata_oe_o` is 0, whatever the bank strobes do.
- R6: `mem_oe_no` is always low. `mem_we_no` equals `vwe_ni` while selected and is high otherwise. `mem_wdata_o` follows `vdata_i`.
- R7: After `ras_ni` returns high, the select, address and direction hold as long as a bank column strobe stays low.
- R8: A row strobe with no column strobe produces no select, but it reloads the row register. A following column-only access uses the refreshed row.
- R9: `vdata_oe_o` is 1 and `vdata_o` equals `mem_rdata_i` only while selected with `vwe_ni` high. Otherwise `vdata_oe_o` is 0 and `vdata_o` is 0.
- R10: If both bank column strobes are sampled low at a clock, `err_o` rises after that clock and stays high until reset. Bank 0 takes bit 16 (value 0).
- R11: After reset, the row register is 0 and `err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vaddr_i | input | 8 | Multiplexed row/column address |
| ras_ni | input | 1 | Row strobe, active low |
| cas0_ni | input | 1 | Bank 0 column strobe, active low |
| cas1_ni | input | 1 | Bank 1 column strobe, active low |
| casx_ni | input | 1 | Expansion column strobe, active low |
| vwe_ni | input | 1 | Controller write enable, active low |
| vdata_i | input | 8 | Write data from controller |
| vdata_o | output | 8 | Read data to controller |
| vdata_oe_o | output | 1 | Read data drive enable |
| err_o | output | 1 | Sticky dual-bank strobe error |
| mem_addr_o | output | 17 | Flat memory address |
| mem_cs_no | output | 1 | Memory chip select, active low |
| mem_we_no | output | 1 | Memory write enable, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data |

## Verification
On every cycle, the assertions check these relations:
- the select only ever comes from a bank strobe, and the expansion strobe vetoes it;
- write enable and read drive appear only inside a select, each with the matching direction;
- bank 0 wins bit 16;
- the error flag never falls;
- the stored row does not move while the row strobe is held low.

Some behaviour only the bench scenarios can show:
- data written through one bank returns unchanged through the same bank, and the two banks stay apart;
- a refresh-only cycle changes the row used by a later column-only access;
- an access outlives the rise of the row strobe.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic {BANK_LO = 1'b0, BANK_HI = 1'b1} bank_e;
endpackage

// File: rtl/bsr_row_capture.sv
module bsr_row_capture #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ras_ni,
  input  logic [AW-1:0] vaddr_i,
  output logic [AW-1:0] row_o
);
  logic ras_q;

  // load on sampled falling edge only; holding low does not reload
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q <= 1'b1;
      row_o <= '0;
    end else begin
      ras_q <= ras_ni;
      if (ras_q && !ras_ni) row_o <= vaddr_i;
    end
  end
endmodule

// File: rtl/bsr_strobe_decode.sv
module bsr_strobe_decode
  import bsr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cas0_ni,
  input  logic  cas1_ni,
  input  logic  casx_ni,
  output logic  sel_o,
  output bank_e bank_o,
  output logic  err_o
);
  logic any_cas, both_cas;

  always_comb begin
    any_cas  = !cas0_ni || !cas1_ni;
    both_cas = !cas0_ni && !cas1_ni;
    sel_o    = any_cas && casx_ni;
    bank_o   = (!cas0_ni) ? BANK_LO : (!cas1_ni ? BANK_HI : BANK_LO);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       err_o <= 1'b0;
    else if (both_cas) err_o <= 1'b1;
  end
endmodule

// File: rtl/bsr_data_steer.sv
module bsr_data_steer #(
  parameter int DW = 8
) (
  input  logic          sel_i,
  input  logic          vwe_ni,
  input  logic [DW-1:0] vdata_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] vdata_o,
  output logic          vdata_oe_o,
  output logic          mem_we_no,
  output logic [DW-1:0] mem_wdata_o
);
  always_comb begin
    mem_we_no   = !(sel_i && !vwe_ni);
    vdata_oe_o  = sel_i && vwe_ni;
    vdata_o     = vdata_oe_o ? mem_rdata_i : '0;
    mem_wdata_o = vdata_i;
  end
endmodule

// File: rtl/dram_sram_bridge.sv
module dram_sram_bridge
  import bsr_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int MAW = 2*AW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  vaddr_i,
  input  logic           ras_ni,
  input  logic           cas0_ni,
  input  logic           cas1_ni,
  input  logic           casx_ni,
  input  logic           vwe_ni,
  input  logic [DW-1:0]  vdata_i,
  output logic [DW-1:0]  vdata_o,
  output logic           vdata_oe_o,
  output logic           err_o,
  output logic [MAW-1:0] mem_addr_o,
  output logic           mem_cs_no,
  output logic           mem_we_no,
  output logic           mem_oe_no,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i
);
  logic [AW-1:0] row;
  logic          sel;
  bank_e         bank;

  bsr_row_capture #(.AW(AW)) u_row (
    .clk_i(clk_i), .rst_ni(rst_ni), .ras_ni(ras_ni),
    .vaddr_i(vaddr_i), .row_o(row)
  );

  bsr_strobe_decode u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .cas0_ni(cas0_ni), .cas1_ni(cas1_ni),
    .casx_ni(casx_ni), .sel_o(sel), .bank_o(bank), .err_o(err_o)
  );

  bsr_data_steer #(.DW(DW)) u_dat (
    .sel_i(sel), .vwe_ni(vwe_ni), .vdata_i(vdata_i), .mem_rdata_i(mem_rdata_i),
    .vdata_o(vdata_o), .vdata_oe_o(vdata_oe_o), .mem_we_no(mem_we_no),
    .mem_wdata_o(mem_wdata_o)
  );

  assign mem_addr_o = {bank, vaddr_i, row};
  assign mem_cs_no  = !sel;
  assign mem_oe_no  = 1'b0;
endmodule

// File: rtl/dram_sram_bridge_chk.sv
module dram_sram_bridge_chk #(
  parameter int MAW = 17
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           ras_ni,
  input logic           cas0_ni,
  input logic           cas1_ni,
  input logic           casx_ni,
  input logic           vwe_ni,
  input logic           vdata_oe_o,
  input logic           err_o,
  input logic [MAW-1:0] mem_addr_o,
  input logic           mem_cs_no,
  input logic           mem_we_no
);
  p_cs_from_cas_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_cs_no |-> (!cas0_ni || !cas1_ni));

  p_x_blocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !casx_ni |-> (mem_cs_no && mem_we_no && !vdata_oe_o));

  p_we_in_sel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_cs_no && !vwe_ni));

  p_rd_drive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vdata_oe_o |-> (!mem_cs_no && vwe_ni));

  p_bank0_first_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas0_ni && !mem_cs_no) |-> !mem_addr_o[MAW-1]);

  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  p_row_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 2) && $past(rst_ni) && !$past(ras_ni, 2))
      |-> $stable(mem_addr_o[7:0]));
endmodule

bind dram_sram_bridge dram_sram_bridge_chk #(.MAW(MAW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ras_ni(ras_ni), .cas0_ni(cas0_ni),
  .cas1_ni(cas1_ni), .casx_ni(casx_ni), .vwe_ni(vwe_ni),
  .vdata_oe_o(vdata_oe_o), .err_o(err_o), .mem_addr_o(mem_addr_o),
  .mem_cs_no(mem_cs_no), .mem_we_no(mem_we_no)
);

// File: tb/dram_sram_bridge_test.sv
module dram_sram_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  vaddr = '0;
  logic        ras_n = 1'b1, cas0_n = 1'b1, cas1_n = 1'b1, casx_n = 1'b1, vwe_n = 1'b1;
  logic [7:0]  vdata_i = '0;
  logic [7:0]  vdata_o;
  logic        vdata_oe, err;
  logic [16:0] maddr;
  logic        mcs_n, mwe_n, moe_n;
  logic [7:0]  mwdata, mrdata;

  int vectors = 0, fails = 0;
  bit done = 0;
  logic [7:0] sram [int];
  logic [7:0] gold [int];

  always #4 clk = ~clk;

  dram_sram_bridge uut (
    .clk_i(clk), .rst_ni(rst_n), .vaddr_i(vaddr), .ras_ni(ras_n),
    .cas0_ni(cas0_n), .cas1_ni(cas1_n), .casx_ni(casx_n), .vwe_ni(vwe_n),
    .vdata_i(vdata_i), .vdata_o(vdata_o), .vdata_oe_o(vdata_oe), .err_o(err),
    .mem_addr_o(maddr), .mem_cs_no(mcs_n), .mem_we_no(mwe_n), .mem_oe_no(moe_n),
    .mem_wdata_o(mwdata), .mem_rdata_i(mrdata)
  );

  // behavioural static RAM
  always @* mrdata = (!mcs_n && sram.exists(int'(maddr))) ? sram[int'(maddr)] : 8'h00;
  always @(posedge clk) if (!mcs_n && !mwe_n && !moe_n) sram[int'(maddr)] = mwdata;

  function automatic logic [7:0] gold_rd(input logic [16:0] a);
    return gold.exists(int'(a)) ? gold[int'(a)] : 8'h00;
  endfunction

  function automatic logic [16:0] flat(input bit bk, input logic [7:0] c, r);
    return {bk, c, r};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input bit bk, input logic [7:0] r, c, input bit wr, input logic [7:0] d);
    logic [16:0] a;
    a = flat(bk, c, r);
    @(negedge clk); vaddr = r; ras_n = 1'b0;
    @(negedge clk); vaddr = c; vwe_n = !wr; vdata_i = d;
    if (bk) cas1_n = 1'b0; else cas0_n = 1'b0;
    #1;
    chk(mcs_n == 1'b0, "R3", int'(mcs_n), 0);
    chk(maddr == a, "R1 R2 R4", int'(maddr), int'(a));
    if (wr) begin
      chk(mwe_n == 1'b0 && moe_n == 1'b0 && mwdata == d, "R6", int'({mwe_n, moe_n, mwdata}), int'(d));
      chk(vdata_oe == 1'b0, "R9", int'(vdata_oe), 0);
    end else begin
      chk(vdata_oe == 1'b1 && vdata_o == gold_rd(a), "R9", int'({vdata_oe, vdata_o}), int'({1'b1, gold_rd(a)}));
    end
    @(negedge clk); ras_n = 1'b1; #1;
    chk(mcs_n == 1'b0 && maddr == a && mwe_n == !wr, "R7", int'({mcs_n, mwe_n}), int'({1'b0, !wr}));
    if (wr) gold[int'(a)] = d;
    @(negedge clk); cas0_n = 1'b1; cas1_n = 1'b1; vwe_n = 1'b1; #1;
    chk(mcs_n == 1'b1 && mwe_n == 1'b1, "R3", int'({mcs_n, mwe_n}), 3);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd1234));
    #3;
    chk(err == 1'b0 && maddr[7:0] == 8'h00, "R11", int'({err, maddr[7:0]}), 0);
    chk(mcs_n == 1'b1 && vdata_oe == 1'b0, "R11", int'({mcs_n, vdata_oe}), 2);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // directed bank separation
    access(1'b0, 8'h12, 8'h34, 1'b1, 8'hA5);
    access(1'b1, 8'h12, 8'h34, 1'b1, 8'h5A);
    access(1'b0, 8'h12, 8'h34, 1'b0, 8'h00);
    access(1'b1, 8'h12, 8'h34, 1'b0, 8'h00);

    // R2 edge capture: bus change while row strobe low
    @(negedge clk); vaddr = 8'h77; ras_n = 1'b0;
    @(negedge clk); vaddr = 8'h99;
    @(negedge clk); vaddr = 8'hC3; #1;
    chk(maddr[7:0] == 8'h77, "R2", int'(maddr[7:0]), 'h77);
    @(negedge clk); ras_n = 1'b1;

    // R8 refresh-only cycle then column-only access
    @(negedge clk); vaddr = 8'h5E; ras_n = 1'b0; #1;
    chk(mcs_n == 1'b1, "R8", int'(mcs_n), 1);
    @(negedge clk); ras_n = 1'b1; #1;
    chk(mcs_n == 1'b1 && mwe_n == 1'b1, "R8", int'({mcs_n, mwe_n}), 3);
    @(negedge clk); vaddr = 8'h21; cas1_n = 1'b0; #1;
    chk(maddr == flat(1'b1, 8'h21, 8'h5E), "R8", int'(maddr), int'(flat(1'b1, 8'h21, 8'h5E)));
    @(negedge clk); cas1_n = 1'b1;

    // R5 expansion strobe blocks select
    @(negedge clk); vaddr = 8'h40; ras_n = 1'b0;
    @(negedge clk); casx_n = 1'b0; vwe_n = 1'b0; #1;
    chk(mcs_n == 1'b1 && mwe_n == 1'b1 && vdata_oe == 1'b0, "R5", int'({mcs_n, mwe_n, vdata_oe}), 6);
    @(negedge clk); cas0_n = 1'b0; #1;
    chk(mcs_n == 1'b1 && mwe_n == 1'b1, "R5", int'({mcs_n, mwe_n}), 3);
    @(negedge clk); casx_n = 1'b1; cas0_n = 1'b1; vwe_n = 1'b1; ras_n = 1'b1;
    @(negedge clk); #1;
    chk(err == 1'b0, "R10", int'(err), 0);

    // R10 both bank strobes
    @(negedge clk); vaddr = 8'h01; ras_n = 1'b0;
    @(negedge clk); vaddr = 8'h02; cas0_n = 1'b0; cas1_n = 1'b0; #1;
    chk(maddr[16] == 1'b0 && mcs_n == 1'b0, "R10", int'({maddr[16], mcs_n}), 0);
    @(negedge clk); #1;
    chk(err == 1'b1, "R10", int'(err), 1);
    cas0_n = 1'b1; cas1_n = 1'b1; ras_n = 1'b1;
    repeat (3) @(negedge clk); #1;
    chk(err == 1'b1, "R10", int'(err), 1);

    // random traffic on a small address window to force reuse
    for (int i = 0; i < 300; i++) begin
      automatic bit         bk = 1'($urandom_range(0, 1));
      automatic logic [7:0] r  = 8'($urandom_range(0, 3));
      automatic logic [7:0] c  = 8'($urandom_range(0, 3) << 6);
      automatic bit         wr = 1'($urandom_range(0, 1));
      automatic logic [7:0] d  = 8'($urandom);
      access(bk, r, c, wr, d);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule